// File: doc/BRIEF.md
# Hot-Plug Slot Event Controller

This block follows the card-presence and data-link-active state of a single downstream port. When either of them changes, it records the change and reports it on three separate channels. A native interrupt request is gated by software enables. An SCI status bit can be routed to the platform's ACPI handling. Per-event SMI status bits set no matter how the other two channels are configured.

Both raw inputs are asynchronous to the block clock. Each one passes through a synchronizer chain. A change is found by comparing the synchronized value with the last registered value. Every latched flag stays set until software writes one to its clear strobe. A hardware set that lands in the same cycle as a software clear wins, so no event is ever lost. The interrupt request is a level signal, not a pulse.

Top module: `hp_slot_evt_ctrl`

## Requirements
- R1: A rise of `prsnt_raw_i` sets `prsnt_o` to 1 and sets `pres_chg_o` to 1.
- R2: A fall of `prsnt_raw_i` clears `prsnt_o` to 0 and sets `pres_chg_o` to 1.
- R3: A change of `lnk_up_raw_i` in either direction sets `link_chg_o` to 1 and leaves `pres_chg_o` unchanged.
- R4: `irq_o` is high exactly while all three of these hold:
  - `en_hp_irq_i` is 1;
  - `en_pres_irq_i` is 1;
  - at least one of `pres_chg_o` or `link_chg_o` is 1.
  It follows the enables and flags combinationally, as a level.
- R5: A presence or link change sets `sci_sts_o` when `en_sci_i` is 1. It leaves `sci_sts_o` untouched when `en_sci_i` is 0.
- R6: When `en_smi_i` is 1, a presence change sets `smi_sts_o[0]` and a link change sets `smi_sts_o[1]`. This holds whatever values the interrupt and SCI enables have.
- R7: `smi_o` is 1 whenever any bit of `smi_sts_o` is 1, and 0 otherwise.
- R8: Each flag is cleared by a one-cycle high pulse on its clear strobe:
  - `sw_clr_chg_i[0]` clears `pres_chg_o`;
  - `sw_clr_chg_i[1]` clears `link_chg_o`;
  - `sw_clr_sci_i` clears `sci_sts_o`;
  - `sw_clr_smi_i[0]` and `sw_clr_smi_i[1]` clear the matching SMI bits.
  A strobe held at 0 leaves its flag alone. A hardware set in the same cycle as a clear leaves the flag at 1.
- R9: While `rst_n` is low, and right after it is released (with both raw inputs low), every output is 0.
- R10: With the default two-stage synchronizer, an input change is first visible at the outputs after the third rising clock edge following the change, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prsnt_raw_i | input | 1 | Raw card-present indication from the physical layer |
| lnk_up_raw_i | input | 1 | Raw data-link-active indication |
| sw_clr_chg_i | input | 2 | Write-one-to-clear strobes: bit 0 presence-changed, bit 1 link-changed |
| sw_clr_sci_i | input | 1 | Write-one-to-clear strobe for the SCI status |
| sw_clr_smi_i | input | 2 | Write-one-to-clear strobes: bit 0 presence SMI, bit 1 link SMI |
| en_pres_irq_i | input | 1 | Presence/link-change interrupt enable |
| en_hp_irq_i | input | 1 | Global hot-plug interrupt enable |
| en_sci_i | input | 1 | Route hot-plug events to the SCI status |
| en_smi_i | input | 1 | Route hot-plug events to the SMI status bits |
| prsnt_o | output | 1 | Synchronized, registered presence state |
| pres_chg_o | output | 1 | Presence-changed flag |
| link_chg_o | output | 1 | Link-active-changed flag |
| irq_o | output | 1 | Level interrupt request |
| sci_sts_o | output | 1 | SCI status flag |
| smi_sts_o | output | 2 | SMI status: bit 0 presence, bit 1 link |
| smi_o | output | 1 | SMI request, the OR of the SMI status bits |

## Verification
The bench walks every combination of the four enables against presence rises, presence falls and link toggles. This catches a design that wires the SMI bits through the interrupt gate, or that swaps the two SMI bit positions. It drives a clear strobe into the very cycle in which a new change is detected. A design that gives the clear priority would then lose the event and show the flag at 0. It also samples one cycle before and at the expected edge, to catch a synchronizer with a missing or extra stage. Finally, it drops the global enable while flags stay pending, to catch an interrupt that was latched instead of held as a level.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

  // Event slots shared by the change, SMI and clear vectors
  typedef enum int unsigned {
    EVT_PRES = 0,
    EVT_LINK = 1
  } hp_evt_e;

  localparam int unsigned NUM_EVT = 2;

  // Next value of a write-one-to-clear bit; a hardware set wins over a clear
  function automatic logic w1c_next(input logic cur, input logic hw_set, input logic sw_clr);
    logic nxt;
    if (hw_set)      nxt = 1'b1;
    else if (sw_clr) nxt = 1'b0;
    else             nxt = cur;
    return nxt;
  endfunction

  // Native interrupt level from the two enables and the pending change flags
  function automatic logic irq_level(input logic glb_en, input logic evt_en,
                                     input logic [NUM_EVT-1:0] pend);
    return glb_en & evt_en & (|pend);
  endfunction

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/hp_change_det.sv
module hp_change_det #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] state_o,
  output logic [WIDTH-1:0] evt_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  assign state_o = prev_q;
  assign evt_o   = sync_i ^ prev_q;

endmodule

// File: rtl/hp_w1c_bits.sv
module hp_w1c_bits
  import hp_slot_pkg::*;
#(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= w1c_next(bit_q, set_i[g], clr_i[g]);
    end
    assign q_o[g] = bit_q;
  end

endmodule

// File: rtl/hp_deliver.sv
module hp_deliver
  import hp_slot_pkg::*;
(
  input  logic               en_hp_irq_i,
  input  logic               en_pres_irq_i,
  input  logic [NUM_EVT-1:0] chg_i,
  input  logic [NUM_EVT-1:0] smi_sts_i,
  output logic               irq_o,
  output logic               smi_o
);

  always_comb begin
    irq_o = irq_level(en_hp_irq_i, en_pres_irq_i, chg_i);
    smi_o = |smi_sts_i;
  end

endmodule

// File: rtl/hp_slot_evt_ctrl.sv
module hp_slot_evt_ctrl
  import hp_slot_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prsnt_raw_i,
  input  logic               lnk_up_raw_i,
  input  logic [NUM_EVT-1:0] sw_clr_chg_i,
  input  logic               sw_clr_sci_i,
  input  logic [NUM_EVT-1:0] sw_clr_smi_i,
  input  logic               en_pres_irq_i,
  input  logic               en_hp_irq_i,
  input  logic               en_sci_i,
  input  logic               en_smi_i,
  output logic               prsnt_o,
  output logic               pres_chg_o,
  output logic               link_chg_o,
  output logic               irq_o,
  output logic               sci_sts_o,
  output logic [NUM_EVT-1:0] smi_sts_o,
  output logic               smi_o
);

  logic [NUM_EVT-1:0] raw_vec;
  logic [NUM_EVT-1:0] sync_vec;
  logic [NUM_EVT-1:0] state_vec;
  logic [NUM_EVT-1:0] evt_vec;
  logic [NUM_EVT-1:0] chg_vec;
  logic [NUM_EVT-1:0] smi_set;
  logic [0:0]         sci_set;
  logic [0:0]         sci_q;

  // Named event wires for the checker
  logic pres_evt;
  logic link_evt;

  assign raw_vec[EVT_PRES] = prsnt_raw_i;
  assign raw_vec[EVT_LINK] = lnk_up_raw_i;

  hp_sync #(.WIDTH(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_vec),
    .q_o   (sync_vec)
  );

  hp_change_det #(.WIDTH(NUM_EVT)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_i  (sync_vec),
    .state_o (state_vec),
    .evt_o   (evt_vec)
  );

  assign pres_evt = evt_vec[EVT_PRES];
  assign link_evt = evt_vec[EVT_LINK];

  hp_w1c_bits #(.WIDTH(NUM_EVT)) u_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (evt_vec),
    .clr_i (sw_clr_chg_i),
    .q_o   (chg_vec)
  );

  assign sci_set[0] = en_sci_i & (|evt_vec);

  hp_w1c_bits #(.WIDTH(1)) u_sci (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (sci_set),
    .clr_i (sw_clr_sci_i),
    .q_o   (sci_q)
  );

  assign smi_set = {NUM_EVT{en_smi_i}} & evt_vec;

  hp_w1c_bits #(.WIDTH(NUM_EVT)) u_smi (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (smi_set),
    .clr_i (sw_clr_smi_i),
    .q_o   (smi_sts_o)
  );

  hp_deliver u_dlv (
    .en_hp_irq_i   (en_hp_irq_i),
    .en_pres_irq_i (en_pres_irq_i),
    .chg_i         (chg_vec),
    .smi_sts_i     (smi_sts_o),
    .irq_o         (irq_o),
    .smi_o         (smi_o)
  );

  assign prsnt_o    = state_vec[EVT_PRES];
  assign pres_chg_o = chg_vec[EVT_PRES];
  assign link_chg_o = chg_vec[EVT_LINK];
  assign sci_sts_o  = sci_q[0];

endmodule

// File: rtl/hp_slot_evt_chk.sv
module hp_slot_evt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pres_evt,
  input logic       link_evt,
  input logic       prsnt_o,
  input logic       pres_chg_o,
  input logic       link_chg_o,
  input logic       irq_o,
  input logic       sci_sts_o,
  input logic [1:0] smi_sts_o,
  input logic       smi_o,
  input logic       en_hp_irq_i,
  input logic       en_sci_i,
  input logic       en_smi_i,
  input logic [1:0] sw_clr_chg_i
);

  assert_pres_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pres_evt |=> pres_chg_o);

  assert_prsnt_flips_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pres_evt |=> (prsnt_o != $past(prsnt_o)));

  assert_prsnt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pres_evt |=> $stable(prsnt_o));

  assert_link_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> link_chg_o);

  assert_irq_needs_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pres_chg_o || link_chg_o));

  assert_irq_needs_glb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_hp_irq_i |-> !irq_o);

  assert_sci_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_sci_i && (pres_evt || link_evt)) |=> sci_sts_o);

  assert_smi_pres_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_smi_i && pres_evt) |=> smi_sts_o[0]);

  assert_smi_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_smi_i && link_evt) |=> smi_sts_o[1]);

  assert_smi_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_sts_o != 2'b00) |-> smi_o);

  assert_pres_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_chg_i[0] && !pres_evt) |=> !pres_chg_o);

  assert_link_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_clr_chg_i[1] && !link_evt) |=> !link_chg_o);

  assert_pres_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pres_chg_o && !sw_clr_chg_i[0]) |=> pres_chg_o);

  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!pres_chg_o && !pres_evt) |=> !pres_chg_o);

endmodule

bind hp_slot_evt_ctrl hp_slot_evt_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pres_evt     (pres_evt),
  .link_evt     (link_evt),
  .prsnt_o      (prsnt_o),
  .pres_chg_o   (pres_chg_o),
  .link_chg_o   (link_chg_o),
  .irq_o        (irq_o),
  .sci_sts_o    (sci_sts_o),
  .smi_sts_o    (smi_sts_o),
  .smi_o        (smi_o),
  .en_hp_irq_i  (en_hp_irq_i),
  .en_sci_i     (en_sci_i),
  .en_smi_i     (en_smi_i),
  .sw_clr_chg_i (sw_clr_chg_i)
);

// File: tb/tb_hp_slot_evt_ctrl.sv
`timescale 1ns/1ps
module tb_hp_slot_evt_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prsnt_raw_i = 1'b0;
  logic       lnk_up_raw_i = 1'b0;
  logic [1:0] sw_clr_chg_i = '0;
  logic       sw_clr_sci_i = 1'b0;
  logic [1:0] sw_clr_smi_i = '0;
  logic       en_pres_irq_i = 1'b0;
  logic       en_hp_irq_i = 1'b0;
  logic       en_sci_i = 1'b0;
  logic       en_smi_i = 1'b0;
  logic       prsnt_o, pres_chg_o, link_chg_o, irq_o, sci_sts_o, smi_o;
  logic [1:0] smi_sts_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  hp_slot_evt_ctrl dut (
    .clk(clk), .rst_n(rst_n), .prsnt_raw_i(prsnt_raw_i), .lnk_up_raw_i(lnk_up_raw_i),
    .sw_clr_chg_i(sw_clr_chg_i), .sw_clr_sci_i(sw_clr_sci_i), .sw_clr_smi_i(sw_clr_smi_i),
    .en_pres_irq_i(en_pres_irq_i), .en_hp_irq_i(en_hp_irq_i), .en_sci_i(en_sci_i),
    .en_smi_i(en_smi_i), .prsnt_o(prsnt_o), .pres_chg_o(pres_chg_o), .link_chg_o(link_chg_o),
    .irq_o(irq_o), .sci_sts_o(sci_sts_o), .smi_sts_o(smi_sts_o), .smi_o(smi_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    sw_clr_chg_i = 2'b11; sw_clr_sci_i = 1'b1; sw_clr_smi_i = 2'b11;
    tick(1);
    sw_clr_chg_i = '0; sw_clr_sci_i = 1'b0; sw_clr_smi_i = '0;
    chk("R8 clear chg", {30'd0, link_chg_o, pres_chg_o}, 0);
    chk("R8 clear sci/smi", {29'd0, sci_sts_o, smi_sts_o}, 0);
  endtask

  initial begin
    bit cur_p;
    bit cur_l;
    cur_p = 1'b0;
    cur_l = 1'b0;
    tick(3);
    chk("R9 reset outputs", {25'd0, prsnt_o, pres_chg_o, link_chg_o, irq_o, sci_sts_o, smi_sts_o, smi_o}, 0);
    rst_n = 1'b1;
    tick(4);
    chk("R9 after release", {25'd0, prsnt_o, pres_chg_o, link_chg_o, irq_o, sci_sts_o, smi_sts_o, smi_o}, 0);

    // R10 latency of the synchronizer plus change register
    lnk_up_raw_i = 1'b1; cur_l = 1'b1;
    tick(2);
    chk("R10 not yet after two edges", int'(link_chg_o), 0);
    tick(1);
    chk("R10 visible after third edge", int'(link_chg_o), 1);
    clear_all();

    // Exhaustive sweep: 16 enable sets x 4 event kinds
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int kind = 0; kind < 4; kind++) begin
        bit is_pres;
        int exp_smi;
        clear_all();
        en_pres_irq_i = cfg[0]; en_hp_irq_i = cfg[1]; en_sci_i = cfg[2]; en_smi_i = cfg[3];
        is_pres = (kind < 2);
        if (is_pres) begin cur_p = ~cur_p; prsnt_raw_i = cur_p; end
        else         begin cur_l = ~cur_l; lnk_up_raw_i = cur_l; end
        tick(3);
        chk(cur_p ? "R1 presence state" : "R2 presence state", int'(prsnt_o), int'(cur_p));
        chk(is_pres ? "R1 R2 pres_chg" : "R3 pres_chg untouched", int'(pres_chg_o), int'(is_pres));
        chk("R3 link_chg", int'(link_chg_o), int'(!is_pres));
        chk("R4 irq level", int'(irq_o), int'(cfg[0] && cfg[1]));
        chk("R5 sci status", int'(sci_sts_o), int'(cfg[2]));
        exp_smi = cfg[3] ? (is_pres ? 1 : 2) : 0;
        chk("R6 smi bits", int'(smi_sts_o), exp_smi);
        chk("R7 smi out", int'(smi_o), int'(exp_smi != 0));
        tick(4);
        chk("R8 zero strobe keeps flag", {30'd0, link_chg_o, pres_chg_o}, is_pres ? 1 : 2);
      end
    end

    // R4: level follows enables and flags
    clear_all();
    en_pres_irq_i = 1'b1; en_hp_irq_i = 1'b1; en_sci_i = 1'b0; en_smi_i = 1'b0;
    cur_p = ~cur_p; prsnt_raw_i = cur_p;
    tick(3);
    chk("R4 irq raised", int'(irq_o), 1);
    en_hp_irq_i = 1'b0; #1;
    chk("R4 irq drops with global enable", int'(irq_o), 0);
    en_hp_irq_i = 1'b1; #1;
    chk("R4 irq returns while pending", int'(irq_o), 1);
    tick(1);
    sw_clr_chg_i = 2'b01; tick(1); sw_clr_chg_i = 2'b00;
    chk("R4 irq drops after clear", int'(irq_o), 0);

    // R8: hardware set wins over a clear in the same cycle
    en_smi_i = 1'b1;
    cur_p = ~cur_p; prsnt_raw_i = cur_p;
    tick(3);
    chk("R8 precondition", int'(pres_chg_o), 1);
    cur_p = ~cur_p; prsnt_raw_i = cur_p;
    tick(2);
    sw_clr_chg_i = 2'b01; sw_clr_smi_i = 2'b01;
    tick(1);
    sw_clr_chg_i = 2'b00; sw_clr_smi_i = 2'b00;
    chk("R8 set beats clear chg", int'(pres_chg_o), 1);
    chk("R8 set beats clear smi", int'(smi_sts_o), 1);
    chk("R1 R2 state after collision", int'(prsnt_o), int'(cur_p));

    // R5: SCI enabled later does not set without a new event
    clear_all();
    en_sci_i = 1'b1;
    tick(3);
    chk("R5 no event no sci", int'(sci_sts_o), 0);
    en_sci_i = 1'b0;
    cur_l = ~cur_l; lnk_up_raw_i = cur_l;
    tick(3);
    chk("R5 disabled sci stays clear", int'(sci_sts_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired before completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule